// File: doc/BRIEF.md
# Serial Channel Clock Routing Matrix

This block picks a clock enable for each of six serial channels from a pool of twelve candidate sources. Four baud-rate generators and eight external clock pins arrive as single-cycle enable pulses in the system clock domain. Four full channels have separate transmit and receive selectors. Two simple channels share one selector between their transmit and receive outputs.

Selection is set by two 32-bit configuration registers. They are updated through a masked write port, so software can change one channel's field without touching any other bit. Each output is a registered mux. A new selector therefore takes effect on the clock after the register write, and a switch between sources never produces a glitch.

Top module: `clk_route_matrix`

## Requirements
- R1: After reset both configuration registers read zero and every enable output is low. With all selectors at zero, every output follows baud-rate generator enable `brg_en[0]`.
- R2: A selector code of 0, 1, 2 or 3 routes `brg_en[code]` to the channel output, whatever the channel.
- R3: For full channels 0 and 1 and simple channel 0 (outputs 4), codes 4 to 7 route `ext_en[code-4]`.
- R4: For full channels 2 and 3 and simple channel 1 (outputs 5), codes 4 to 7 route `ext_en[code]`, which is the upper pin bank.
- R5: Full channel c (c = 0..3) takes its transmit selector from register A bits [8c+2:8c] and its receive selector from register A bits [8c+5:8c+3].
- R6: Simple channel 0 takes its selector from register B bits [14:12] and simple channel 1 from bits [30:28]. The selector drives both `tx_en` and `rx_en` of that channel (index 4 and 5).
- R7: A write with `cfg_wr` high updates only the bits of the chosen register (`cfg_sel` 0 = A, 1 = B) where `cfg_wmask` is 1. All other bits of that register and the whole other register keep their values.
- R8: Bits outside the selector fields read back as written and have no effect on any output.
- R9: Each output is registered. The value seen after a clock edge is the selected source as sampled at that edge, using the selector held in the register at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select, 0 = A, 1 = B |
| cfg_wdata | input | 32 | Write data |
| cfg_wmask | input | 32 | Per-bit write mask, 1 = update |
| brg_en | input | 4 | Baud-rate generator enables |
| ext_en | input | 8 | External clock pin enables |
| cfg_a_q | output | 32 | Register A contents |
| cfg_b_q | output | 32 | Register B contents |
| tx_en | output | 6 | Transmit clock enables, 0-3 full, 4-5 simple |
| rx_en | output | 6 | Receive clock enables, 0-3 full, 4-5 simple |

## Verification
The hardest case to reach from the ports is the bank split. A wrong pin bank on a single channel and code only shows when that exact channel holds a code from 4 to 7 while the matching pin, and no other, is pulsing. The stimulus programs every field with offset codes, so all channels hold different codes at once. It then walks a one-hot enable across all twelve sources for each of the eight code rotations, so every channel meets every code against every source. Partial masked writes and writes to unused bits are mixed in to show that neighbouring fields survive.

// File: rtl/clk_route_pkg.sv
package clk_route_pkg;
  localparam int SEL_W    = 3;
  localparam int N_BRG    = 4;
  localparam int N_PIN    = 8;
  localparam int N_SRC    = N_BRG + N_PIN;
  localparam int N_FULL   = 4;
  localparam int N_SIMPLE = 2;
  localparam int N_CH     = N_FULL + N_SIMPLE;
  localparam int SRC_IW   = $clog2(N_SRC);

  // field placement: receive sits directly above transmit
  function automatic int full_tx_lsb(input int ch);
    return 8 * ch;
  endfunction

  function automatic int full_rx_lsb(input int ch);
    return 8 * ch + SEL_W;
  endfunction

  function automatic int simple_lsb(input int ch);
    return 12 + 16 * ch;
  endfunction

  // source vector layout: [3:0] generators, [7:4] low pins, [11:8] high pins
  function automatic logic [SRC_IW-1:0] route_idx(input logic [SEL_W-1:0] code,
                                                  input logic hi_bank);
    if (!code[2]) return {2'b00, code[1:0]};
    return {hi_bank, ~hi_bank, code[1:0]};
  endfunction
endpackage

// File: rtl/clk_route_cfg.sv
module clk_route_cfg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] wmask,
  output logic [REG_W-1:0] reg_a,
  output logic [REG_W-1:0] reg_b
);
  logic wr_a, wr_b;
  assign wr_a = wr && !sel;
  assign wr_b = wr && sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (wr_a) reg_a <= (reg_a & ~wmask) | (wdata & wmask);
      if (wr_b) reg_b <= (reg_b & ~wmask) | (wdata & wmask);
    end
  end

  // R7
  a_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> ((reg_a & ~$past(wmask)) == ($past(reg_a) & ~$past(wmask))) && $stable(reg_b));
  // R7
  b_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> ((reg_b & ~$past(wmask)) == ($past(reg_b) & ~$past(wmask))) && $stable(reg_a));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(reg_a) && $stable(reg_b));
endmodule

// File: rtl/clk_route_chan.sv
module clk_route_chan
  import clk_route_pkg::*;
#(
  parameter bit HI_BANK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] src,
  output logic             en_q
);
  logic [SRC_IW-1:0] pick_idx;
  logic              pick_val;

  assign pick_idx = route_idx(sel, HI_BANK);
  assign pick_val = src[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= pick_val;
  end

  // R9
  quiet_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |=> !en_q);
  // R9
  full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&src) |=> en_q);
  // R2
  brg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel[2] && src[N_SRC-1:N_BRG] == '0 && src[N_BRG-1:0] == '0) |=> !en_q);
endmodule

// File: rtl/clk_route_matrix.sv
module clk_route_matrix
  import clk_route_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [REG_W-1:0] cfg_wmask,
  input  logic [N_BRG-1:0] brg_en,
  input  logic [N_PIN-1:0] ext_en,
  output logic [REG_W-1:0] cfg_a_q,
  output logic [REG_W-1:0] cfg_b_q,
  output logic [N_CH-1:0]  tx_en,
  output logic [N_CH-1:0]  rx_en
);
  logic [N_SRC-1:0] src_vec;
  assign src_vec = {ext_en, brg_en};

  clk_route_cfg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .wmask(cfg_wmask),
    .reg_a(cfg_a_q), .reg_b(cfg_b_q)
  );

  for (genvar c = 0; c < N_FULL; c++) begin : g_full
    localparam bit HI = (c >= N_FULL / 2);
    clk_route_chan #(.HI_BANK(HI)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .sel(cfg_a_q[full_tx_lsb(c) +: SEL_W]),
      .src(src_vec), .en_q(tx_en[c])
    );
    clk_route_chan #(.HI_BANK(HI)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .sel(cfg_a_q[full_rx_lsb(c) +: SEL_W]),
      .src(src_vec), .en_q(rx_en[c])
    );
  end

  for (genvar s = 0; s < N_SIMPLE; s++) begin : g_simple
    localparam bit HI = (s >= N_SIMPLE / 2);
    logic en_s;
    clk_route_chan #(.HI_BANK(HI)) u_one (
      .clk(clk), .rst_n(rst_n),
      .sel(cfg_b_q[simple_lsb(s) +: SEL_W]),
      .src(src_vec), .en_q(en_s)
    );
    assign tx_en[N_FULL + s] = en_s;
    assign rx_en[N_FULL + s] = en_s;
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_a_q == '0) && (cfg_b_q == '0) && (tx_en == '0) && (rx_en == '0));
endmodule

// File: tb/clk_route_matrix_tb.sv
module clk_route_matrix_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_wmask = '0;
  logic [3:0]  brg_en = '0;
  logic [7:0]  ext_en = '0;
  logic [31:0] cfg_a_q, cfg_b_q;
  logic [5:0]  tx_en, rx_en;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] sh_a = '0, sh_b = '0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clk_route_matrix u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_wmask(cfg_wmask),
    .brg_en(brg_en), .ext_en(ext_en),
    .cfg_a_q(cfg_a_q), .cfg_b_q(cfg_b_q), .tx_en(tx_en), .rx_en(rx_en)
  );

  // selector code -> source: 0..3 generators, 4..7 pins of the channel's bank
  function automatic bit pick(input int code, input bit hi, input logic [11:0] s);
    if (code < 4) return s[code];
    return s[code + (hi ? 4 : 0)];
  endfunction

  function automatic logic [11:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [11:0] s);
    logic [5:0] t, r;
    for (int ch = 0; ch < 6; ch++) begin
      int ts, rs;
      bit hi;
      if (ch < 4) begin
        ts = int'((a >> (ch * 8)) & 32'd7);
        rs = int'((a >> (ch * 8 + 3)) & 32'd7);
        hi = (ch >= 2);
      end else begin
        ts = int'((b >> (12 + 16 * (ch - 4))) & 32'd7);
        rs = ts;
        hi = (ch == 5);
      end
      t[ch] = pick(ts, hi, s);
      r[ch] = pick(rs, hi, s);
    end
    return {r, t};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input bit which, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = which; cfg_wdata = d; cfg_wmask = m;
    if (which) sh_b = (sh_b & ~m) | (d & m);
    else       sh_a = (sh_a & ~m) | (d & m);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wmask = '0;
  endtask

  // drive sources, wait one edge, compare outputs (R9 latency)
  task automatic drive_and_check(input string req, input logic [11:0] s);
    @(negedge clk);
    {ext_en, brg_en} = s;
    @(posedge clk);
    #1;
    check(req, {20'd0, rx_en, tx_en}, {20'd0, model(sh_a, sh_b, s)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 cfg_a", cfg_a_q, 32'd0);
    check("R1 cfg_b", cfg_b_q, 32'd0);
    check("R1 outputs", {20'd0, rx_en, tx_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive_and_check("R1 follow generator 0", 12'h001);
    drive_and_check("R1 ignore generator 1", 12'h002);
    check("R1 all follow", {20'd0, rx_en, tx_en}, 32'd0);

    // R2 R3 R4 R5 R6 sweep: every channel, every code, every source
    for (int code = 0; code < 8; code++) begin
      logic [31:0] a, b;
      a = 32'hC0C0_C0C0 & {4{8'(code * 37)}};
      for (int c = 0; c < 4; c++) begin
        a |= 32'((code + c) % 8) << (8 * c);
        a |= 32'((code + 5 + c) % 8) << (8 * c + 3);
      end
      b = 32'h8FFF_0FFF & {16'(code * 4099), 16'(code * 1234)};
      b |= 32'((code + 2) % 8) << 12;
      b |= 32'((code + 6) % 8) << 28;
      write_reg(1'b0, a, 32'hFFFF_FFFF);
      write_reg(1'b1, b, 32'hFFFF_FFFF);
      #1;
      check("R8 readback A", cfg_a_q, sh_a);
      check("R8 readback B", cfg_b_q, sh_b);
      for (int s = 0; s < 12; s++) begin
        if (s < 4)      drive_and_check("R2 generator route R5 R6", 12'(1 << s));
        else if (s < 8) drive_and_check("R3 low pin bank R5 R6", 12'(1 << s));
        else            drive_and_check("R4 high pin bank R5 R6", 12'(1 << s));
      end
      drive_and_check("R9 quiet sources", 12'h000);
      drive_and_check("R9 mixed sources", 12'(12'h5A3 ^ (code * 291)));
    end

    // R7 masked field update in B keeps everything else
    write_reg(1'b1, 32'hFFFF_FFFF, 32'h0000_7000);
    #1;
    check("R7 B masked field", cfg_b_q, sh_b);
    check("R7 A untouched", cfg_a_q, sh_a);
    write_reg(1'b0, 32'h0000_0000, 32'h0000_3F00);
    #1;
    check("R7 A masked field", cfg_a_q, sh_a);
    check("R7 B untouched", cfg_b_q, sh_b);
    for (int s = 0; s < 12; s++) drive_and_check("R7 routing after partial write", 12'(1 << s));

    // R8 unused bits toggled: routing unchanged
    write_reg(1'b0, 32'hFFFF_FFFF, 32'hC0C0_C0C0);
    write_reg(1'b1, 32'hFFFF_FFFF, 32'h8FFF_0FFF);
    #1;
    check("R8 unused A", cfg_a_q, sh_a);
    check("R8 unused B", cfg_b_q, sh_b);
    for (int s = 0; s < 12; s++) drive_and_check("R8 routing unaffected", 12'(1 << s));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule